// File: doc/BRIEF.md
# 16-bit Compare/Capture Timer with PWM and One-Pulse Modes

The block is a 16-bit up-counter with two compare channels, two capture channels and overflow detection. Each compare channel drives an output pin, and each capture channel samples an input pin. A CPU reaches the block through an 8-bit register port, reading and writing 16-bit values as separate high and low bytes. Status flags record compare matches, capture events and counter wrap. Each flag can feed a single interrupt line, subject to a per-group enable bit and a global mask input.

There are two sequencing modes besides free running. In PWM mode, compare 2 ends the period: on a match it reloads the counter and marks the period end in capture flag 1. Compare 1 sets the duty edge, and capture input 1 is cut off. In one-pulse mode, an edge on capture input 1 restarts the counter and starts a pulse that compare 1 ends. While the halt input is high, the timer freezes. A capture edge seen during halt is held pending and completes when the wake pulse arrives.

Top module: `tmr16_top`

## Requirements
- R1: After reset the counter is FFFCh, all flags are clear, both compare pins are low and irq_o is low.
- R2: The counter advances by one every clock when not halted. A step from FFFFh to 0000h sets TOF (status bit 4). The counter high byte reads at address 7 and the low byte at address 8.
- R3: Outside PWM mode, a compare match sets OCF1 or OCF2 (status bits 2 and 3) and drives that channel's pin to its level bit (control bit 0 for pin 1, bit 1 for pin 2). Compare 1 is written at addresses 5 (high) and 6 (low). Compare 2 is written at addresses 11 (high) and 12 (low).
- R4: A compare channel is disarmed from reset until its low byte is first written. Writing its high byte disarms it again until the next low-byte write.
- R5: On the selected edge of a capture pin, the current count is copied into that channel's capture register and ICF1 or ICF2 (status bits 0 and 1) is set. The edge register is at address 1: bit 0 is channel 1, bit 1 is channel 2, and 1 selects rising while 0 selects falling. Capture 1 reads at addresses 3 and 4, and capture 2 at addresses 9 and 10.
- R6: A flag clears only when two things happen in order: a read of the status register (address 2) while the flag is set, and then an access to the flag's low data byte. ICF1 uses address 4, ICF2 address 10, OCF1 address 6, OCF2 address 12 and TOF address 8. Accessing the low byte without that status read leaves the flag set.
- R7: irq_o is high when irq_mask_i is low and some flag is set whose enable is on. The enables are control bit 4 for OCF1 and OCF2, bit 5 for ICF1 and ICF2, and bit 6 for TOF.
- R8: PWM mode is control bit 2. In PWM mode, pin 1 drives level 1 from the compare 1 match until the compare 2 match, then level 2. A compare 2 match reloads FFFCh and sets ICF1. OCF1 and OCF2 are never set.
- R9: In PWM mode, edges on capture pin 1 are ignored, while capture pin 2 still captures and sets ICF2.
- R10: When both control bit 2 and the one-pulse bit (control bit 3) are set, only PWM mode acts. A capture-1 edge then neither reloads the counter nor moves pin 1.
- R11: In one-pulse mode, the capture-1 edge reloads FFFCh and drives pin 1 to level 2. The next compare 1 match drives level 1.
- R12: While halt_i is high, the counter, compares and captures are frozen. Counting resumes from the held value once halt_i falls.
- R13: A capture edge during halt sets no flag, but arms the channel. A wake_i pulse then sets the flag and captures the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (drives flag-clear side effects) |
| rdata_o | output | 8 | Read data for addr_i |
| cap1_i | input | 1 | Capture input 1 |
| cap2_i | input | 1 | Capture input 2 |
| cmp1_o | output | 1 | Compare output 1 |
| cmp2_o | output | 1 | Compare output 2 |
| halt_i | input | 1 | Freeze request |
| wake_i | input | 1 | Wake pulse that completes pending captures |
| irq_mask_i | input | 1 | Global interrupt mask |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every cycle. The count holds while halted, and a PWM period-end match always reloads FFFCh. In PWM mode no compare flag rises, and capture flag 1 rises only at a period-end match. The global mask always silences irq_o, and TOF rises only right after the count was FFFFh. The bench scenarios cover what those properties cannot see. These are the exact captured values, the PWM duty count over two full periods, the one-pulse delay from trigger to pulse end, and the byte-level arming rules of the compares. They also cover the status-read-then-access clear order and the pending capture completed by wake.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int AW = 4;
  localparam int NFLAG = 5;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_EDGE  = 4'd1;
  localparam logic [AW-1:0] A_STAT  = 4'd2;
  localparam logic [AW-1:0] A_CAP1H = 4'd3;
  localparam logic [AW-1:0] A_CAP1L = 4'd4;
  localparam logic [AW-1:0] A_CMP1H = 4'd5;
  localparam logic [AW-1:0] A_CMP1L = 4'd6;
  localparam logic [AW-1:0] A_CNTH  = 4'd7;
  localparam logic [AW-1:0] A_CNTL  = 4'd8;
  localparam logic [AW-1:0] A_CAP2H = 4'd9;
  localparam logic [AW-1:0] A_CAP2L = 4'd10;
  localparam logic [AW-1:0] A_CMP2H = 4'd11;
  localparam logic [AW-1:0] A_CMP2L = 4'd12;

  // control bit positions
  localparam int C_LVL1 = 0;
  localparam int C_LVL2 = 1;
  localparam int C_PWM  = 2;
  localparam int C_OPM  = 3;
  localparam int C_OCIE = 4;
  localparam int C_ICIE = 5;
  localparam int C_TOIE = 6;
  localparam int CTRL_W = 7;

  // status bit positions
  localparam int F_ICF1 = 0;
  localparam int F_ICF2 = 1;
  localparam int F_OCF1 = 2;
  localparam int F_OCF2 = 3;
  localparam int F_TOF  = 4;

  function automatic logic [AW-1:0] cmp_hi_addr(input int ch);
    return (ch == 0) ? A_CMP1H : A_CMP2H;
  endfunction

  function automatic logic [AW-1:0] cmp_lo_addr(input int ch);
    return (ch == 0) ? A_CMP1L : A_CMP2L;
  endfunction

  // low data byte whose access completes the clear of flag k
  function automatic logic [AW-1:0] clr_addr(input int k);
    case (k)
      F_ICF1:  return A_CAP1L;
      F_ICF2:  return A_CAP2L;
      F_OCF1:  return A_CMP1L;
      F_OCF2:  return A_CMP2L;
      default: return A_CNTL;
    endcase
  endfunction
endpackage

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int          CW   = 16,
  parameter logic [CW-1:0] INIT = 16'hFFFC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          halt_i,
  input  logic          reload_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= INIT;
    else if (!halt_i) cnt_q <= reload_i ? INIT : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = !halt_i && !reload_i && (&cnt_q);
endmodule

// File: rtl/tmr16_cmp.sv
module tmr16_cmp #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [CW/2-1:0] wdata_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          halt_i,
  output logic [CW-1:0] val_o,
  output logic          match_o
);
  localparam int HW = CW / 2;

  logic [CW-1:0] val_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '0;
      armed_q <= 1'b0;
    end else if (wr_hi_i) begin
      val_q[CW-1:HW] <= wdata_i;
      armed_q        <= 1'b0;
    end else if (wr_lo_i) begin
      val_q[HW-1:0] <= wdata_i;
      armed_q       <= 1'b1;
    end
  end

  assign val_o   = val_q;
  assign match_o = armed_q && !halt_i && (cnt_i == val_q);
endmodule

// File: rtl/tmr16_cap.sv
module tmr16_cap #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_i,
  input  logic          rise_i,
  input  logic          en_i,
  input  logic          halt_i,
  input  logic          wake_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] cap_o,
  output logic          evt_o
);
  logic          prev_q, pend_q, edge_hit;
  logic [CW-1:0] cap_q;

  assign edge_hit = en_i && (rise_i ? (pin_i && !prev_q) : (!pin_i && prev_q));
  assign evt_o    = (edge_hit && !halt_i) || (en_i && wake_i && pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      prev_q <= pin_i;
      if (evt_o) cap_q <= cnt_i;
      if (wake_i && pend_q)         pend_q <= 1'b0;
      else if (edge_hit && halt_i)  pend_q <= 1'b1;
    end
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int            CW   = 16,
  parameter logic [CW-1:0] INIT = 16'hFFFC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      addr_i,
  input  logic [CW/2-1:0] wdata_i,
  input  logic            we_i,
  input  logic            re_i,
  output logic [CW/2-1:0] rdata_o,
  input  logic            cap1_i,
  input  logic            cap2_i,
  output logic            cmp1_o,
  output logic            cmp2_o,
  input  logic            halt_i,
  input  logic            wake_i,
  input  logic            irq_mask_i,
  output logic            irq_o
);
  localparam int HW = CW / 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        edge_q;
  logic [NFLAG-1:0]  flags_q, arm_q, flag_set, flag_clr;
  logic [1:0]        pin_q;
  logic [CW-1:0]     cnt;
  logic              ovf, reload, pwm, opm;
  logic [1:0]        match, cap_evt, cap_pin;
  logic [CW-1:0]     cmp_val [2];
  logic [CW-1:0]     cap_val [2];

  assign pwm     = ctrl_q[C_PWM];
  assign opm     = ctrl_q[C_OPM] && !pwm;  // PWM dominates
  assign cap_pin = {cap2_i, cap1_i};
  assign reload  = (pwm && match[1]) || (opm && cap_evt[0]);

  tmr16_counter #(.CW(CW), .INIT(INIT)) u_cnt (
    .clk_i, .rst_ni, .halt_i, .reload_i(reload), .cnt_o(cnt), .ovf_o(ovf)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ch
    tmr16_cmp #(.CW(CW)) u_cmp (
      .clk_i, .rst_ni,
      .wr_hi_i(we_i && addr_i == cmp_hi_addr(g)),
      .wr_lo_i(we_i && addr_i == cmp_lo_addr(g)),
      .wdata_i, .cnt_i(cnt), .halt_i,
      .val_o(cmp_val[g]), .match_o(match[g])
    );
    tmr16_cap #(.CW(CW)) u_cap (
      .clk_i, .rst_ni,
      .pin_i(cap_pin[g]), .rise_i(edge_q[g]),
      .en_i((g != 0) || !pwm),  // input 1 cut off in PWM
      .halt_i, .wake_i, .cnt_i(cnt),
      .cap_o(cap_val[g]), .evt_o(cap_evt[g])
    );
  end

  always_comb begin
    flag_set         = '0;
    flag_set[F_ICF1] = cap_evt[0] || (pwm && match[1]);
    flag_set[F_ICF2] = cap_evt[1];
    flag_set[F_OCF1] = !pwm && match[0];
    flag_set[F_OCF2] = !pwm && match[1];
    flag_set[F_TOF]  = ovf;
    for (int k = 0; k < NFLAG; k++)
      flag_clr[k] = (we_i || re_i) && (addr_i == clr_addr(k)) && arm_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      edge_q  <= '0;
      flags_q <= '0;
      arm_q   <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (we_i && addr_i == A_EDGE) edge_q <= wdata_i[1:0];
      flags_q <= flag_set | (flags_q & ~flag_clr);
      arm_q   <= (re_i && addr_i == A_STAT) ? flags_q : (arm_q & ~flag_clr);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= '0;
    end else begin
      if (pwm && match[1])          pin_q[0] <= ctrl_q[C_LVL2];
      else if (opm && cap_evt[0])   pin_q[0] <= ctrl_q[C_LVL2];
      else if (match[0])            pin_q[0] <= ctrl_q[C_LVL1];
      if (!pwm && match[1])         pin_q[1] <= ctrl_q[C_LVL2];
    end
  end

  assign cmp1_o = pin_q[0];
  assign cmp2_o = pin_q[1];

  assign irq_o = !irq_mask_i && (
      (ctrl_q[C_OCIE] && (flags_q[F_OCF1] || flags_q[F_OCF2])) ||
      (ctrl_q[C_ICIE] && (flags_q[F_ICF1] || flags_q[F_ICF2])) ||
      (ctrl_q[C_TOIE] && flags_q[F_TOF]));

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = HW'(ctrl_q);
      A_EDGE:  rdata_o = HW'(edge_q);
      A_STAT:  rdata_o = HW'(flags_q);
      A_CAP1H: rdata_o = cap_val[0][CW-1:HW];
      A_CAP1L: rdata_o = cap_val[0][HW-1:0];
      A_CMP1H: rdata_o = cmp_val[0][CW-1:HW];
      A_CMP1L: rdata_o = cmp_val[0][HW-1:0];
      A_CNTH:  rdata_o = cnt[CW-1:HW];
      A_CNTL:  rdata_o = cnt[HW-1:0];
      A_CAP2H: rdata_o = cap_val[1][CW-1:HW];
      A_CAP2L: rdata_o = cap_val[1][HW-1:0];
      A_CMP2H: rdata_o = cmp_val[1][CW-1:HW];
      A_CMP2L: rdata_o = cmp_val[1][HW-1:0];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int            CW   = 16,
  parameter logic [CW-1:0] INIT = 16'hFFFC
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          halt_i,
  input logic          irq_mask_i,
  input logic          irq_o,
  input logic          pwm_i,
  input logic          m2_i,
  input logic [CW-1:0] cnt_i,
  input logic          icf1_i,
  input logic          ocf1_i,
  input logic          ocf2_i,
  input logic          tof_i
);
  assert_halt_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> $stable(cnt_i));

  assert_pwm_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && m2_i && !halt_i) |=> (cnt_i == INIT));

  assert_no_ocf1_pwm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !ocf1_i) |=> !ocf1_i);

  assert_no_ocf2_pwm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !ocf2_i) |=> !ocf2_i);

  assert_cap1_cut_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !m2_i && !icf1_i) |=> !icf1_i);

  assert_irq_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_i |-> !irq_o);

  assert_tof_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tof_i) |-> ($past(cnt_i) == {CW{1'b1}}));
endmodule

bind tmr16_top tmr16_chk #(.CW(CW), .INIT(INIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt_i),
  .irq_mask_i(irq_mask_i), .irq_o(irq_o),
  .pwm_i(pwm), .m2_i(match[1]), .cnt_i(cnt),
  .icf1_i(flags_q[0]), .ocf1_i(flags_q[2]), .ocf2_i(flags_q[3]), .tof_i(flags_q[4])
);

// File: tb/tb_tmr16_top.sv
module tb_tmr16_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       we_i = 1'b0, re_i = 1'b0;
  logic       cap1_i = 1'b0, cap2_i = 1'b0, cmp1_o, cmp2_o;
  logic       halt_i = 1'b1, wake_i = 1'b0, irq_mask_i = 1'b0, irq_o;

  int n_tests = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  tmr16_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr_i = a; re_i = 1'b1; #1 d = rdata_o;
    @(negedge clk_i); re_i = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] ah, input logic [3:0] al, output logic [15:0] v);
    logic [7:0] h, l;
    rd(ah, h); rd(al, l); v = {h, l};
  endtask

  task automatic do_reset();
    halt_i = 1'b1; rst_ni = 1'b0; cap1_i = 0; cap2_i = 0; wake_i = 0; irq_mask_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic run(input int n);
    halt_i = 1'b0; repeat (n) @(negedge clk_i); halt_i = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] v; logic [7:0] s;
    do_reset();
    rd16(7, 8, v);  chk("R1 count", v, 16'hFFFC);
    rd(2, s);       chk("R1 status", s, 0);
    chk("R1 pins", {cmp2_o, cmp1_o}, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_overflow();
    logic [15:0] v; logic [7:0] s;
    do_reset();
    wr(0, 8'h40);
    run(8);
    rd16(7, 8, v);   chk("R2 count after 8", v, 16'h0004);  // lo read, no status read yet
    rd(2, s);        chk("R2 TOF set", s[4], 1);
                     chk("R4 unarmed compares", s[3:2], 0);
                     chk("R6 no clear without status read", s[4], 1);
    #1               chk("R7 irq on TOF", irq_o, 1);
    irq_mask_i = 1;  #1 chk("R7 masked", irq_o, 0);
    irq_mask_i = 0;
    rd(8, s);        // completes clear sequence
    rd(2, s);        chk("R6 TOF cleared", s[4], 0);
    #1               chk("R7 irq dropped", irq_o, 0);
  endtask

  task automatic t_compare();
    logic [7:0] s;
    do_reset();
    wr(0, 8'h03);
    wr(5, 8'h00); wr(6, 8'h03);
    wr(11, 8'h00); wr(12, 8'h05); wr(11, 8'h00);  // re-disarm compare 2
    run(12);
    rd(2, s);
    chk("R3 OCF1", s[2], 1);
    chk("R3 pin1", cmp1_o, 1);
    chk("R4 OCF2 disarmed", s[3], 0);
    chk("R4 pin2 held", cmp2_o, 0);
    wr(12, 8'h0A);
    run(6);
    rd(2, s);
    chk("R4 OCF2 rearmed", s[3], 1);
    chk("R3 pin2", cmp2_o, 1);
  endtask

  task automatic t_capture();
    logic [15:0] v; logic [7:0] s;
    do_reset();
    wr(0, 8'h20); wr(1, 8'h03);
    halt_i = 0; cap1_i = 1; @(negedge clk_i); halt_i = 1;
    rd16(3, 4, v);  chk("R5 capture1 value", v, 16'hFFFC);
    rd(2, s);       chk("R5 ICF1", s[0], 1);
    #1              chk("R7 irq on ICF1", irq_o, 1);
    wr(1, 8'h01);   // channel 2 falling
    halt_i = 0; cap2_i = 1; @(negedge clk_i); halt_i = 1;
    rd(2, s);       chk("R5 rising ignored on falling select", s[1], 0);
    halt_i = 0; cap2_i = 0; @(negedge clk_i); halt_i = 1;
    rd16(9, 10, v); chk("R5 capture2 value", v, 16'hFFFE);
    rd(2, s);       chk("R5 ICF2", s[1], 1);
  endtask

  task automatic t_halt();
    logic [15:0] v; logic [7:0] s;
    do_reset();
    wr(1, 8'h03);
    run(5);
    rd16(7, 8, v);  chk("R12 held count", v, 16'h0001);
    repeat (4) @(negedge clk_i);
    rd16(7, 8, v);  chk("R12 still held", v, 16'h0001);
    cap2_i = 1; repeat (3) @(negedge clk_i);
    rd(2, s);       chk("R13 no flag during halt", s[1], 0);
    wake_i = 1; @(negedge clk_i); wake_i = 0;
    rd(2, s);       chk("R13 flag on wake", s[1], 1);
    rd16(9, 10, v); chk("R13 wake capture value", v, 16'h0001);
    run(3);
    rd16(7, 8, v);  chk("R12 resumed count", v, 16'h0004);
  endtask

  task automatic t_pwm();
    logic [15:0] v; logic [7:0] s; int highs;
    do_reset();
    wr(1, 8'h03); wr(0, 8'h0D);  // PWM + one-pulse + level1 high
    wr(5, 8'h00); wr(6, 8'h02); wr(11, 8'h00); wr(12, 8'h08);
    cap1_i = 1; cap2_i = 1; repeat (2) @(negedge clk_i);
    wake_i = 1; @(negedge clk_i); wake_i = 0;
    rd(2, s);
    chk("R9 capture1 cut off", s[0], 0);
    chk("R9 capture2 active", s[1], 1);
    rd16(9, 10, v); chk("R9 capture2 value", v, 16'hFFFC);
    halt_i = 0;
    repeat (3) @(negedge clk_i);
    cap1_i = 0; @(negedge clk_i); cap1_i = 1;  // would retrigger in one-pulse mode
    repeat (30) @(negedge clk_i);
    highs = 0;
    for (int i = 0; i < 26; i++) begin
      if (cmp1_o) highs++;
      @(negedge clk_i);
    end
    halt_i = 1;
    chk("R8 duty over two periods", highs, 12);
    chk("R10 one-pulse inert in PWM", highs, 12);
    rd(2, s);
    chk("R8 no OCF1/OCF2", s[3:2], 0);
    chk("R8 ICF1 at period end", s[0], 1);
    rd16(7, 8, v);
    chk("R8 count within period", (v <= 16'h0008 || v >= 16'hFFFC), 1);
  endtask

  task automatic t_opm();
    logic [7:0] s;
    do_reset();
    wr(1, 8'h03); wr(0, 8'h09);  // one-pulse, level1 high, level2 low
    wr(5, 8'h00); wr(6, 8'h05);
    halt_i = 0;
    repeat (20) @(negedge clk_i);
    chk("R11 pin1 before trigger", cmp1_o, 1);
    cap1_i = 1; @(negedge clk_i);
    chk("R11 trigger drives level2", cmp1_o, 0);
    repeat (8) @(negedge clk_i);
    chk("R11 pulse still active", cmp1_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R11 compare1 ends pulse", cmp1_o, 1);
    halt_i = 1;
    rd(2, s);
    chk("R11 ICF1 on trigger", s[0], 1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_overflow();
    t_compare();
    t_capture();
    t_halt();
    t_pwm();
    t_opm();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule